// File: doc/BRIEF.md
# Multiplexed Bus Register Read Interface

This block is the read side of a slave port that sits on a 16-bit processor's multiplexed address/data bus. An address strobe marks the address phase. On its falling edge the block keeps the low eight address bits and the two low byte enables. A later data phase opens when chip select and read strobe are both low. The block then decodes the kept address, picks either the register-file read port or the FIFO head, and registers the result. It raises a per-lane output enable for each lane the byte enables asked for. The pad tristate buffers sit outside and follow those enables.

All bus inputs cross into the internal clock through a flop synchronizer chain before any edge is detected. Ordinary registers can only be read one byte at a time. The FIFO-data register and a small run of counter registers can also be read as 16-bit words. A read that asks for the high lane of a byte-only register returns zero on that lane and gets a one-cycle width-error flag. At the end of each FIFO-data read, the block sends the FIFO one pop pulse together with the number of bytes consumed.

Top module: `mux_bus_rd_if`

## Requirements
- R1: On the falling edge of `ale_i` (as seen after synchronization), the block keeps `ad_i[7:0]` as the register address and drives it on `reg_addr_o`. Bits 31..8 of `ad_i` have no effect.
- R2: The kept address and byte enables stay in use for any number of further reads until `ale_i` falls again. A repeated read of the same location needs no new address phase.
- R3: `be_n_i[0]` low enables lane 0 (`lane_oe_o[0]`, data bits 7..0). `be_n_i[1]` low enables lane 1 (`lane_oe_o[1]`, bits 15..8). A lane is enabled only while `cs_n_i` and `rd_n_i` are both low. `be_n_i[3:2]` have no effect.
- R4: Both lane enables drop at the third rising clock edge after `rd_n_i` or `cs_n_i` goes high (two synchronizer flops, then one register).
- R5: Read data and lane enables appear at the third rising clock edge after `cs_n_i` and `rd_n_i` are both low. The data is sampled from the register port at that edge, and the register port is addressed combinationally by `reg_addr_o`.
- R6: The word-capable addresses are `FIFO_ADDR` (default 0x80) and `CNT_BASE` to `CNT_BASE+CNT_NUM-1` (default 0x0C to 0x0F). For these, each enabled lane carries its own byte of the source, with no width error. The source is `fifo_rdata_i` for the FIFO address and `reg_rdata_i` otherwise. A disabled lane reads zero.
- R7: For any other address, lane 0 carries `reg_rdata_i[7:0]`. If lane 1 is enabled, lane 1 reads zero and `width_err_o` pulses high for exactly one cycle.
- R8: Each FIFO-data read raises `fifo_pop_o` for exactly one cycle after the read strobe ends. `fifo_pop_cnt_o` gives the number of enabled lanes (2 for a word, 1 for a byte). A FIFO read with no lane enabled, and any read of another address, produce no pop.
- R9: While reset is applied and right after it, lane enables, read data, `width_err_o`, `fifo_pop_o` and `fifo_pop_cnt_o` are all zero.
- R10: A read may end in the same cycle that `ale_i` falls with a new address. In that case the pop is decided by the read that just ended, and the new address applies to the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ale_i | input | 1 | Address strobe, address kept on its falling edge |
| cs_n_i | input | 1 | Chip select, active low |
| rd_n_i | input | 1 | Read strobe, active low |
| be_n_i | input | 4 | Byte enables, active low; only bits 1..0 are used |
| ad_i | input | 32 | Multiplexed address/data bus, address phase only |
| reg_addr_o | output | 8 | Kept register address to the register-file read port |
| reg_rdata_i | input | 16 | Combinational register-file read data |
| fifo_rdata_i | input | 16 | Next two FIFO bytes, the head in bits 7..0 |
| rd_data_o | output | 16 | Registered read data for the data pads |
| lane_oe_o | output | 2 | Per-lane drive enables for the pad buffers |
| width_err_o | output | 1 | One-cycle flag for an illegal wide read |
| fifo_pop_o | output | 1 | One-cycle FIFO pop request |
| fifo_pop_cnt_o | output | 2 | Bytes consumed by the pop |

## Verification
The FIFO pop of a finished read and the capture of a new address can land on the same clock edge. The bench provokes this by raising the address strobe with a fresh address while a FIFO word read is still open. It then lowers the address strobe in the same input cycle as it releases the read and chip-select strobes. The outcome is judged two ways. The pop tally must grow by exactly one event of two bytes. A following read with no new address phase must return the new register's data and pop nothing.

// File: rtl/mux_bus_rd_if.sv
module mux_bus_rd_if #(
  parameter int            BUS_W     = 32,
  parameter int            AW        = 8,
  parameter int            DW        = 16,
  parameter int            SYNC_N    = 2,
  parameter logic [AW-1:0] FIFO_ADDR = AW'(8'h80),
  parameter logic [AW-1:0] CNT_BASE  = AW'(8'h0C),
  parameter int            CNT_NUM   = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ale_i,
  input  logic             cs_n_i,
  input  logic             rd_n_i,
  input  logic [3:0]       be_n_i,
  input  logic [BUS_W-1:0] ad_i,
  output logic [AW-1:0]    reg_addr_o,
  input  logic [DW-1:0]    reg_rdata_i,
  input  logic [DW-1:0]    fifo_rdata_i,
  output logic [DW-1:0]    rd_data_o,
  output logic [DW/8-1:0]  lane_oe_o,
  output logic             width_err_o,
  output logic             fifo_pop_o,
  output logic [$clog2(DW/8+1)-1:0] fifo_pop_cnt_o
);
  localparam int LANES = DW / 8;
  localparam int PCW   = $clog2(LANES + 1);
  localparam int SW    = AW + 3 + LANES;
  localparam logic [SW-1:0] IDLE = {{AW{1'b0}}, 1'b0, 1'b1, 1'b1, {LANES{1'b1}}};

  logic unused_bits;
  assign unused_bits = ^{ad_i[BUS_W-1:AW], be_n_i[3:LANES]};

  // input synchronizer chain, strobes parked at their idle levels in reset
  logic [SW-1:0] sync_q [SYNC_N];
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < SYNC_N; k++) sync_q[k] <= IDLE;
    end else begin
      sync_q[0] <= {ad_i[AW-1:0], ale_i, cs_n_i, rd_n_i, be_n_i[LANES-1:0]};
      for (int k = 1; k < SYNC_N; k++) sync_q[k] <= sync_q[k-1];
    end
  end

  logic [SW-1:0]    s;
  logic [AW-1:0]    ad_s;
  logic [LANES-1:0] be_s;
  logic             ale_s, rd_act;
  assign s      = sync_q[SYNC_N-1];
  assign ad_s   = s[SW-1 -: AW];
  assign ale_s  = s[LANES+2];
  assign rd_act = !s[LANES+1] && !s[LANES];
  assign be_s   = s[LANES-1:0];

  logic ale_d, act_d;
  logic ale_fall, rd_start, rd_end;
  assign ale_fall = ale_d && !ale_s;
  assign rd_start = rd_act && !act_d;
  assign rd_end   = !rd_act && act_d;

  logic [AW-1:0]    addr_q;
  logic [LANES-1:0] be_q;
  assign reg_addr_o = addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ale_d  <= 1'b0;
      act_d  <= 1'b0;
      addr_q <= '0;
      be_q   <= '1;
    end else begin
      ale_d <= ale_s;
      act_d <= rd_act;
      if (ale_fall) begin
        addr_q <= ad_s;
        be_q   <= be_s;
      end
    end
  end

  // address decode and source select
  logic             is_fifo, is_cnt, wide_ok, illegal;
  logic [LANES-1:0] lanes;
  logic [DW-1:0]    src, cap;
  assign is_fifo = (addr_q == FIFO_ADDR);
  assign is_cnt  = ({1'b0, addr_q} >= {1'b0, CNT_BASE}) &&
                   ({1'b0, addr_q} <  ({1'b0, CNT_BASE} + (AW+1)'(CNT_NUM)));
  assign wide_ok = is_fifo || is_cnt;
  assign lanes   = ~be_q;
  assign illegal = (|lanes[LANES-1:1]) && !wide_ok;
  assign src     = is_fifo ? fifo_rdata_i : reg_rdata_i;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    if (g == 0) begin : g_low
      assign cap[7:0] = lanes[0] ? src[7:0] : 8'h00;
    end else begin : g_high
      assign cap[g*8 +: 8] = (lanes[g] && wide_ok) ? src[g*8 +: 8] : 8'h00;
    end
  end

  // data phase
  logic [LANES-1:0] oe_q, rd_lanes_q;
  logic [DW-1:0]    data_q;
  logic             err_q, pop_q, rd_fifo_q;
  logic [PCW-1:0]   pcnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oe_q       <= '0;
      rd_lanes_q <= '0;
      data_q     <= '0;
      err_q      <= 1'b0;
      pop_q      <= 1'b0;
      pcnt_q     <= '0;
      rd_fifo_q  <= 1'b0;
    end else begin
      err_q  <= 1'b0;
      pop_q  <= 1'b0;
      pcnt_q <= '0;
      if (rd_start) begin
        oe_q       <= lanes;
        rd_lanes_q <= lanes;
        data_q     <= cap;
        err_q      <= illegal;
        rd_fifo_q  <= is_fifo;
      end else if (!rd_act) begin
        oe_q <= '0;
      end
      if (rd_end && rd_fifo_q && (|rd_lanes_q)) begin
        pop_q  <= 1'b1;
        pcnt_q <= PCW'($countones(rd_lanes_q));
      end
    end
  end

  assign rd_data_o      = data_q;
  assign lane_oe_o      = oe_q;
  assign width_err_o    = err_q;
  assign fifo_pop_o     = pop_q;
  assign fifo_pop_cnt_o = pcnt_q;

  assert_addr_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !ale_fall |=> $stable(addr_q));
  assert_lane_needs_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_oe_o != '0) |-> $past(rd_act));
  assert_lanes_steady_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((lane_oe_o != '0) && ($past(lane_oe_o) != '0)) |-> $stable(lane_oe_o));
  assert_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_act |=> (lane_oe_o == '0));
  assert_err_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    width_err_o |=> !width_err_o);
  assert_err_high_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    width_err_o |-> (rd_data_o[DW-1:8] == '0));
  assert_pop_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_pop_o |=> !fifo_pop_o);
  assert_pop_count_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_pop_o |-> (fifo_pop_cnt_o != '0));
  assert_pop_after_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_pop_o |-> ($past(act_d) && !$past(rd_act)));
endmodule

// File: tb/test_mux_bus_rd_if.sv
`timescale 1ns/1ps
module test_mux_bus_rd_if;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ale_i = 1'b0, cs_n_i = 1'b1, rd_n_i = 1'b1;
  logic [3:0]  be_n_i = 4'hF;
  logic [31:0] ad_i = '0;
  logic [7:0]  reg_addr_o;
  logic [15:0] reg_rdata_i, fifo_rdata_i, rd_data_o;
  logic [1:0]  lane_oe_o, fifo_pop_cnt_o;
  logic        width_err_o, fifo_pop_o;

  always #2.5 clk = ~clk;

  mux_bus_rd_if i_mux_bus_rd_if (
    .clk(clk), .rst_n(rst_n), .ale_i(ale_i), .cs_n_i(cs_n_i), .rd_n_i(rd_n_i),
    .be_n_i(be_n_i), .ad_i(ad_i), .reg_addr_o(reg_addr_o), .reg_rdata_i(reg_rdata_i),
    .fifo_rdata_i(fifo_rdata_i), .rd_data_o(rd_data_o), .lane_oe_o(lane_oe_o),
    .width_err_o(width_err_o), .fifo_pop_o(fifo_pop_o), .fifo_pop_cnt_o(fifo_pop_cnt_o));

  // environment models: register file and FIFO head
  logic [7:0] head = 8'h40;
  assign reg_rdata_i  = {reg_addr_o ^ 8'hC3, reg_addr_o ^ 8'h3C};
  assign fifo_rdata_i = {head + 8'd1, head};
  int err_pulses = 0, pop_events = 0, pop_bytes = 0;
  always @(posedge clk) begin
    if (fifo_pop_o) head <= head + 8'(fifo_pop_cnt_o);
    if (width_err_o) err_pulses <= err_pulses + 1;
    if (fifo_pop_o) begin
      pop_events <= pop_events + 1;
      pop_bytes  <= pop_bytes + int'(fifo_pop_cnt_o);
    end
  end

  int tests = 0, fails = 0;
  logic [7:0] exp_head = 8'h40;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] expect_data(input logic [7:0] a, input logic [1:0] ben, input logic [7:0] h);
    logic [15:0] sv;
    logic wide;
    wide = (a == 8'h80) || (a >= 8'h0C && a <= 8'h0F);
    sv = (a == 8'h80) ? {h + 8'd1, h} : {a ^ 8'hC3, a ^ 8'h3C};
    return {(!ben[1] && wide) ? sv[15:8] : 8'h00, !ben[0] ? sv[7:0] : 8'h00};
  endfunction

  task automatic addr_phase(input logic [7:0] a, input logic [1:0] ben, input logic [1:0] hi);
    ad_i = {24'(32'(a) * 32'd977 + 32'd13), a};
    be_n_i = {hi, ben};
    ale_i = 1'b1;
    repeat (3) @(negedge clk);
    ale_i = 1'b0;
    repeat (4) @(negedge clk);
    ad_i = 32'hF0F0_F0F0;
  endtask

  task automatic data_phase(output logic [15:0] d, output logic [1:0] oe);
    cs_n_i = 1'b0; rd_n_i = 1'b0;
    repeat (6) @(negedge clk);
    d = rd_data_o; oe = lane_oe_o;
    rd_n_i = 1'b1; cs_n_i = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  typedef struct packed {
    logic [7:0] addr;
    logic [1:0] be_n;
    logic       new_addr;
    logic [1:0] oe;
    logic       err;
    logic [1:0] pops;
  } vec_t;

  localparam vec_t VEC [12] = '{
    '{8'h23, 2'b10, 1'b1, 2'b01, 1'b0, 2'd0},
    '{8'h23, 2'b10, 1'b0, 2'b01, 1'b0, 2'd0},
    '{8'h0C, 2'b00, 1'b1, 2'b11, 1'b0, 2'd0},
    '{8'h0F, 2'b00, 1'b1, 2'b11, 1'b0, 2'd0},
    '{8'h10, 2'b00, 1'b1, 2'b11, 1'b1, 2'd0},
    '{8'h0B, 2'b00, 1'b1, 2'b11, 1'b1, 2'd0},
    '{8'h80, 2'b00, 1'b1, 2'b11, 1'b0, 2'd2},
    '{8'h80, 2'b00, 1'b0, 2'b11, 1'b0, 2'd2},
    '{8'h80, 2'b10, 1'b1, 2'b01, 1'b0, 2'd1},
    '{8'h80, 2'b01, 1'b1, 2'b10, 1'b0, 2'd1},
    '{8'h81, 2'b01, 1'b1, 2'b10, 1'b1, 2'd0},
    '{8'h80, 2'b11, 1'b1, 2'b00, 1'b0, 2'd0}
  };

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [15:0] d, ed;
    logic [1:0]  oe;
    int e0, p0, b0;
    repeat (3) @(negedge clk);
    check("R9 oe in reset", 32'(lane_oe_o), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R9 data after reset", 32'(rd_data_o), 0);
    check("R9 flags after reset", {29'd0, width_err_o, fifo_pop_o, |fifo_pop_cnt_o}, 0);

    foreach (VEC[i]) begin
      if (VEC[i].new_addr) addr_phase(VEC[i].addr, VEC[i].be_n, 2'b11);
      check("R1 reg_addr_o", 32'(reg_addr_o), 32'(VEC[i].addr));
      e0 = err_pulses; p0 = pop_events; b0 = pop_bytes;
      ed = expect_data(VEC[i].addr, VEC[i].be_n, exp_head);
      data_phase(d, oe);
      check("R6 R7 read data", 32'(d), 32'(ed));
      check("R3 lane enables", 32'(oe), 32'(VEC[i].oe));
      check("R4 lanes released", 32'(lane_oe_o), 0);
      check("R7 width error pulses", err_pulses - e0, 32'(VEC[i].err));
      check("R8 pop events", pop_events - p0, (VEC[i].pops != 0) ? 1 : 0);
      check("R8 pop bytes", pop_bytes - b0, 32'(VEC[i].pops));
      exp_head = exp_head + 8'(VEC[i].pops);
    end

    // R5 / R4: exact edge of drive and release
    addr_phase(8'h2A, 2'b10, 2'b11);
    cs_n_i = 1'b0; rd_n_i = 1'b0;
    repeat (2) @(posedge clk); #1;
    check("R5 not driven after two edges", 32'(lane_oe_o), 0);
    @(posedge clk); #1;
    check("R5 driven at third edge", 32'(lane_oe_o), 32'h1);
    check("R5 data at third edge", 32'(rd_data_o), 32'(8'h2A ^ 8'h3C));
    @(negedge clk);
    rd_n_i = 1'b1;
    repeat (2) @(posedge clk); #1;
    check("R4 still driven after two edges", 32'(lane_oe_o), 32'h1);
    @(posedge clk); #1;
    check("R4 released at third edge", 32'(lane_oe_o), 0);
    @(negedge clk); cs_n_i = 1'b1;
    repeat (4) @(negedge clk);

    // R3: chip select alone high keeps lanes off
    rd_n_i = 1'b0;
    repeat (6) @(negedge clk);
    check("R3 no drive without chip select", 32'(lane_oe_o), 0);
    rd_n_i = 1'b1;
    repeat (4) @(negedge clk);

    // R3: upper byte enables ignored
    addr_phase(8'h0D, 2'b00, 2'b00);
    data_phase(d, oe);
    check("R3 upper enables ignored data", 32'(d), 32'(expect_data(8'h0D, 2'b00, exp_head)));
    check("R3 upper enables ignored lanes", 32'(oe), 32'h3);

    // R10: read end coincides with a new address strobe fall
    addr_phase(8'h80, 2'b00, 2'b11);
    p0 = pop_events; b0 = pop_bytes;
    cs_n_i = 1'b0; rd_n_i = 1'b0;
    repeat (6) @(negedge clk);
    check("R10 fifo word during overlap", 32'(rd_data_o), 32'({exp_head + 8'd1, exp_head}));
    ad_i = {24'hABCDEF, 8'h05}; be_n_i = 4'b1110; ale_i = 1'b1;
    repeat (3) @(negedge clk);
    rd_n_i = 1'b1; cs_n_i = 1'b1; ale_i = 1'b0;
    repeat (6) @(negedge clk);
    check("R10 one pop for ended read", pop_events - p0, 1);
    check("R10 two bytes popped", pop_bytes - b0, 2);
    exp_head = exp_head + 8'd2;
    check("R10 new address kept", 32'(reg_addr_o), 32'h05);
    p0 = pop_events;
    data_phase(d, oe);
    check("R10 next read uses new address", 32'(d), 32'(8'h05 ^ 8'h3C));
    check("R10 no pop on register read", pop_events - p0, 0);
    check("R8 fifo head consistent", 32'(head), 32'(exp_head));

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule